// File: doc/BRIEF.md
# Byte-Lane Static Memory with Single-Error Correction

This block is a synthesizable model of a static word memory with a synchronous core. Each word is 16 bits wide. It is reached through a 19-bit address and controlled by active-low strobes in the usual asynchronous-memory style. A location is accessed only when both chip selects agree: the low-true select is low and the high-true select is high. Two active-low lane enables choose which bytes take part. The upper lane covers bits 15:8 and the lower lane covers bits 7:0. Each stored word carries five Hamming check bits and one overall parity bit. A write computes these bits over the merged word, so a partial write becomes a read-modify-write of the stored word. A read returns the corrected word and raises a flag for one cycle when a bit was repaired. The repaired codeword is also written back to the array.

The data bus is split into an input, an output and a per-lane drive enable, which a pad ring can turn into tri-state buffers. A standby output marks the cycles in which no access can take place, so power gating can use it. A test port flips any chosen bit of a stored codeword, which lets a bench exercise every correctable error position. The populated array is 2**MEM_AW words. Addresses whose bits at or above MEM_AW are not zero are treated as outside the device.

Top module: `ecc_sram`

## Requirements
- R1: With both selects active and both lanes enabled, a write (`wr_n` low on a clock edge) stores `din`. A later read (`wr_n` high, `rd_n` low) presents that word on `dout` one clock edge after the read is sampled, with `dout_en` = 2'b11 and `fix_flag` low.
- R2: A write stores only the enabled lanes: `hi_n` low writes bits 15:8 and `lo_n` low writes bits 7:0. The other lane keeps its stored, corrected value.
- R3: On a read, `dout_en[1]` drives bits 15:8 only when `hi_n` was low, and `dout_en[0]` drives bits 7:0 only when `lo_n` was low.
- R4: The device is selected only when `sel_n` is low and `sel_p` is high. Otherwise a write changes nothing and a read drives no lane.
- R5: With `rd_n` high and `wr_n` high, `dout_en` stays 2'b00.
- R6: When `wr_n` and `rd_n` are both low, the write takes place and `dout_en` stays 2'b00 in the following cycle.
- R7: `standby` is high, combinationally, whenever both lane enables are high or the device is not selected. In that state no write takes place and no lane is driven.
- R8: If exactly one bit of the addressed 22-bit codeword is wrong, a read still returns the written data. `fix_flag` is then high for exactly the one cycle in which that read's data is presented.
- R9: After a corrected read, the repaired codeword is stored back, so a second read of the same address reports `fix_flag` low.
- R10: While `rst_n` is low on a clock edge, `dout_en` becomes 2'b00 and `fix_flag` becomes low.
- R11: With `inj_en` high on a clock edge, bit `inj_bit` of the codeword at `addr` is inverted and no read or write occurs in that cycle. Bit 0 is the overall parity bit, bits 1 to 21 are Hamming positions, and values of 22 or more change nothing.
- R12: An address with any bit at or above MEM_AW set is outside the device. It raises `standby`, writes nothing and drives no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output enable |
| hi_n | input | 1 | Active-low enable for bits 15:8 |
| lo_n | input | 1 | Active-low enable for bits 7:0 |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, corrected |
| dout_en | output | 2 | Drive enable per lane, bit 1 for the upper byte |
| fix_flag | output | 1 | One-cycle flag for a corrected read |
| standby | output | 1 | No access possible this cycle |
| inj_en | input | 1 | Flip one stored codeword bit |
| inj_bit | input | 5 | Codeword bit to flip |

## Verification
The assertions assume that the control strobes are stable around each clock edge and that at most one bit of any codeword is wrong when it is read. A second flip before a repair would make a double error, which the code cannot correct. The stimulus keeps to this rule: every injection of a fault is followed by a read of the same location before any further fault is injected. Sweeps write distinct patterns to every populated location and move through every codeword bit position and every combination of lanes and selects. A shadow model in the bench gives the expected data, lane enables and flags.

// File: rtl/ecc_sram_pkg.sv
// Shared widths, types and code layout for the ECC static memory.
// Assumes a 16-bit data word protected by a Hamming code plus overall parity.
package ecc_sram_pkg;
    localparam int DATA_W  = 16;
    localparam int CHK_W   = 5;
    localparam int CODE_W  = DATA_W + CHK_W + 1;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int BIDX_W  = $clog2(CODE_W);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CODE_W-1:0] code_t;

    // Returns the Hamming position (1..CODE_W-1, never a power of two) of data bit j.
    function automatic int unsigned pos_of(input int unsigned j);
        int unsigned p;
        int unsigned n;
        p = 0;
        n = 0;
        for (int unsigned q = 1; q < CODE_W; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == j) p = q;
                n++;
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
// Hamming encoder: places data bits at non-power-of-two positions, fills the
// check positions 1,2,4,8,16 and sets bit 0 to give even overall parity.
// Assumes: purely combinational, no state.
module ecc_sram_enc
    import ecc_sram_pkg::*;
(
    input  word_t data,
    output code_t code
);
    // Build the codeword from the data word.
    always_comb begin
        code_t c;
        c = '0;
        for (int unsigned j = 0; j < DATA_W; j++) begin
            c[pos_of(j)] = data[j];
        end
        for (int unsigned k = 0; k < CHK_W; k++) begin
            logic b;
            b = 1'b0;
            for (int unsigned q = 1; q < CODE_W; q++) begin
                if (((q >> k) & 1) == 1 && q != (1 << k)) b = b ^ c[q];
            end
            c[1 << k] = b;
        end
        c[0] = ^c[CODE_W-1:1];
        code = c;
    end
endmodule

// File: rtl/ecc_sram_dec.sv
// Hamming decoder with overall parity: an odd parity means a single-bit
// error, whose position is the syndrome (zero means the parity bit itself).
// Assumes at most one bit in error; double errors are not flagged.
module ecc_sram_dec
    import ecc_sram_pkg::*;
(
    input  code_t code,
    output word_t data,
    output code_t fixed,
    output logic  corrected
);
    logic [CHK_W-1:0] syn;
    logic             perr;

    // Syndrome and overall parity of the stored codeword.
    always_comb begin
        syn = '0;
        for (int unsigned q = 1; q < CODE_W; q++) begin
            if (code[q]) syn = syn ^ CHK_W'(q);
        end
        perr = ^code;
    end

    // Invert the faulty bit and extract the data field.
    always_comb begin
        fixed = code;
        if (perr && (int'(syn) < CODE_W)) fixed[syn] = ~code[syn];
        for (int unsigned j = 0; j < DATA_W; j++) begin
            data[j] = fixed[pos_of(j)];
        end
        corrected = perr;
    end
endmodule

// File: rtl/ecc_sram_ctrl.sv
// Access decoder: turns the active-low strobes, dual chip selects, lane
// enables and address range into write/read requests and a standby flag.
// Assumes MEM_AW < ADDR_W; strobes are sampled by the core clock.
module ecc_sram_ctrl
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int MEM_AW = 10
) (
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  lane_en,
    output logic              wr_go,
    output logic              rd_go,
    output logic              standby
);
    logic chip_on;
    logic in_range;

    // Decode selection, lanes and request type.
    always_comb begin
        lane_en  = {~hi_n, ~lo_n};
        in_range = (addr[ADDR_W-1:MEM_AW] == '0);
        chip_on  = ~sel_n & sel_p & in_range;
        standby  = ~chip_on | ~(|lane_en);
        wr_go    = ~standby & ~wr_n;
        rd_go    = ~standby & wr_n & ~rd_n;
    end
endmodule

// File: rtl/ecc_sram.sv
// Top of the ECC static memory. One access per clock: writes merge the
// enabled lanes into the corrected stored word and re-encode it; reads
// register corrected data with per-lane drive enables and write repaired
// codewords back. A test port flips one stored codeword bit.
// Assumes synchronous active-low reset; the array itself is not reset.
module ecc_sram
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en,
    output logic              fix_flag,
    output logic              standby,
    input  logic              inj_en,
    input  logic [4:0]        inj_bit
);
    localparam int DEPTH = 1 << MEM_AW;

    code_t              mem [DEPTH];
    logic [MEM_AW-1:0]  idx;
    logic [LANES-1:0]   lane_en;
    logic               wr_go, rd_go;
    code_t              rd_code, fixed_code, wr_code;
    word_t              rd_data, merged;
    logic               rd_fix;
    code_t              flip_mask;
    word_t              dout_q;
    logic [LANES-1:0]   en_q;
    logic               fix_q;

    ecc_sram_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_ctrl (
        .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .rd_n(rd_n),
        .hi_n(hi_n), .lo_n(lo_n), .addr(addr),
        .lane_en(lane_en), .wr_go(wr_go), .rd_go(rd_go), .standby(standby)
    );

    // Location index and current stored codeword.
    always_comb begin
        idx     = addr[MEM_AW-1:0];
        rd_code = mem[idx];
    end

    ecc_sram_dec u_dec (
        .code(rd_code), .data(rd_data), .fixed(fixed_code), .corrected(rd_fix)
    );

    // Merge write data into the corrected word lane by lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] =
            lane_en[g] ? din[g*LANE_W +: LANE_W] : rd_data[g*LANE_W +: LANE_W];
    end

    ecc_sram_enc u_enc (.data(merged), .code(wr_code));

    // Single-bit mask for the error-injection port.
    always_comb begin
        flip_mask = '0;
        if (int'(inj_bit) < CODE_W) flip_mask[inj_bit] = 1'b1;
    end

    // Array update: injection, write, or write-back of a repaired read.
    always_ff @(posedge clk) begin
        if (inj_en) begin
            mem[idx] <= rd_code ^ flip_mask;
        end else if (wr_go) begin
            mem[idx] <= wr_code;
        end else if (rd_go && rd_fix) begin
            mem[idx] <= fixed_code;
        end
    end

    // Registered read data, lane drive enables and correction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            en_q   <= '0;
            fix_q  <= 1'b0;
        end else begin
            en_q  <= '0;
            fix_q <= 1'b0;
            if (!inj_en && rd_go) begin
                dout_q <= rd_data;
                en_q   <= lane_en;
                fix_q  <= rd_fix;
            end
        end
    end

    assign dout     = dout_q;
    assign dout_en  = en_q;
    assign fix_flag = fix_q;

    // A write cycle never leaves a lane driven afterwards.
    assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rd_n) |=> (dout_en == 2'b00));

    // Standby means nothing is driven in the next cycle.
    assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (dout_en == 2'b00));

    // Driven lanes match the lane enables of the sampled read.
    assert_lane_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en != 2'b00) |-> (dout_en == ~$past({hi_n, lo_n})));

    // A driven lane requires both selects active in the sampled cycle.
    assert_select_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en != 2'b00) |-> $past(!sel_n && sel_p));

    // The correction flag only follows a read.
    assert_flag_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_flag |-> $past(rd_go && !inj_en));
endmodule

// File: tb/sim_ecc_sram.sv
module sim_ecc_sram;
    localparam int AW    = 19;
    localparam int MAW   = 10;
    localparam int DEPTH = 1 << MAW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, sel_n, sel_p, wr_n, rd_n, hi_n, lo_n, inj_en, fix_flag, standby;
    logic [AW-1:0] addr;
    logic [15:0]   din, dout;
    logic [1:0]    dout_en;
    logic [4:0]    inj_bit;

    ecc_sram #(.ADDR_W(AW), .MEM_AW(MAW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n),
        .rd_n(rd_n), .hi_n(hi_n), .lo_n(lo_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .fix_flag(fix_flag), .standby(standby),
        .inj_en(inj_en), .inj_bit(inj_bit)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model [DEPTH];
    logic [15:0] q;
    logic [1:0]  en;
    logic        f;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 0; sel_p = 1; wr_n = 1; rd_n = 1; hi_n = 1; lo_n = 1; inj_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic hn, input logic ln);
        addr = a; din = d; wr_n = 0; rd_n = 1; hi_n = hn; lo_n = ln;
        step();
        idle();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic hn, input logic ln);
        addr = a; wr_n = 1; rd_n = 0; hi_n = hn; lo_n = ln;
        step();
        q = dout; en = dout_en; f = fix_flag;
        idle();
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [4:0] b);
        addr = a; inj_bit = b; inj_en = 1;
        step();
        idle();
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 40503) ^ 16'h5A5A);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        addr = '0; din = '0; inj_bit = '0; rst_n = 0;
        rd_n = 0; hi_n = 0; lo_n = 0;
        repeat (3) step();
        chk(dout_en == 2'b00, "R10 lanes after reset", 32'(dout_en), 0);
        chk(fix_flag == 1'b0, "R10 flag after reset", 32'(fix_flag), 0);
        idle();
        rst_n = 1;
        step();

        // R1: full-word sweep over every populated location
        for (int a = 0; a < DEPTH; a++) begin
            wr(AW'(a), pat(a), 0, 0);
            model[a] = pat(a);
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), 0, 0);
            chk(q == model[a] && en == 2'b11 && !f, "R1 read back", {q, 14'(0), en}, {model[a], 16'h0003});
        end

        // R2: lane-masked writes
        for (int a = 0; a < 32; a++) begin
            logic [15:0] d;
            d = ~pat(a + 77);
            if (a % 2 == 0) begin
                wr(AW'(a), d, 0, 1);
                model[a][15:8] = d[15:8];
            end else begin
                wr(AW'(a), d, 1, 0);
                model[a][7:0] = d[7:0];
            end
            rd(AW'(a), 0, 0);
            chk(q == model[a], "R2 lane write", 32'(q), 32'(model[a]));
        end

        // R3: read lane enables
        rd(AW'(9), 0, 1);
        chk(en == 2'b10 && q[15:8] == model[9][15:8], "R3 upper lane read", {q, 14'(0), en}, {model[9], 16'h0002});
        rd(AW'(9), 1, 0);
        chk(en == 2'b01 && q[7:0] == model[9][7:0], "R3 lower lane read", {q, 14'(0), en}, {model[9], 16'h0001});

        // R5: output enable off
        addr = AW'(9); hi_n = 0; lo_n = 0;
        step();
        chk(dout_en == 2'b00, "R5 no drive without output enable", 32'(dout_en), 0);
        idle();

        // R4: deselected writes and reads
        sel_n = 1; addr = AW'(3); din = 16'hDEAD; wr_n = 0; hi_n = 0; lo_n = 0;
        step();
        idle();
        sel_p = 0; addr = AW'(3); din = 16'hBEEF; wr_n = 0; hi_n = 0; lo_n = 0;
        step();
        idle();
        rd(AW'(3), 0, 0);
        chk(q == model[3], "R4 deselected write ignored", 32'(q), 32'(model[3]));
        sel_n = 1; addr = AW'(3); rd_n = 0; hi_n = 0; lo_n = 0;
        step();
        chk(dout_en == 2'b00, "R4 no drive with sel_n high", 32'(dout_en), 0);
        idle();
        sel_p = 0; addr = AW'(3); rd_n = 0; hi_n = 0; lo_n = 0;
        step();
        chk(dout_en == 2'b00, "R4 no drive with sel_p low", 32'(dout_en), 0);
        idle();

        // R12: out-of-range address
        addr = AW'(DEPTH + 3); hi_n = 0; lo_n = 0;
        #1;
        chk(standby == 1'b1, "R12 standby out of range", 32'(standby), 1);
        idle();
        wr(AW'(DEPTH + 3), 16'h1234, 0, 0);
        rd(AW'(DEPTH + 3), 0, 0);
        chk(en == 2'b00, "R12 no drive out of range", 32'(en), 0);
        rd(AW'(3), 0, 0);
        chk(q == model[3], "R12 alias untouched", 32'(q), 32'(model[3]));

        // R6: write wins over output enable
        addr = AW'(11); din = 16'hC3A5; wr_n = 0; rd_n = 0; hi_n = 0; lo_n = 0;
        step();
        chk(dout_en == 2'b00, "R6 no drive during write", 32'(dout_en), 0);
        idle();
        model[11] = 16'hC3A5;
        rd(AW'(11), 0, 0);
        chk(q == 16'hC3A5, "R6 write performed", 32'(q), 32'hC3A5);

        // R7: standby decoding and its effect
        addr = AW'(11); hi_n = 1; lo_n = 1;
        #1;
        chk(standby == 1'b1, "R7 standby with lanes off", 32'(standby), 1);
        hi_n = 0;
        #1;
        chk(standby == 1'b0, "R7 active with a lane on", 32'(standby), 0);
        sel_n = 1; hi_n = 1;
        #1;
        chk(standby == 1'b1, "R7 standby when deselected, lanes off", 32'(standby), 1);
        idle();
        wr(AW'(11), 16'h0F0F, 1, 1);
        rd(AW'(11), 0, 0);
        chk(q == model[11], "R7 write with lanes off ignored", 32'(q), 32'(model[11]));

        // R8, R9, R11: every codeword bit position, several patterns
        for (int p = 0; p < 4; p++) begin
            logic [15:0] d;
            d = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'hA55A : pat(p * 13);
            for (int b = 0; b < 22; b++) begin
                wr(AW'(20 + p), d, 0, 0);
                inject(AW'(20 + p), 5'(b));
                rd(AW'(20 + p), 0, 0);
                chk(q == d && f, "R8 single-bit correction", {q, 15'(0), f}, {d, 16'h0001});
                step();
                chk(!fix_flag, "R8 flag lasts one cycle", 32'(fix_flag), 0);
                rd(AW'(20 + p), 0, 0);
                chk(q == d && !f, "R9 repaired word written back", {q, 15'(0), f}, {d, 16'h0000});
            end
            model[20 + p] = d;
        end

        // R11: indexes past the codeword change nothing
        for (int b = 22; b < 32; b++) begin
            inject(AW'(21), 5'(b));
            rd(AW'(21), 0, 0);
            chk(q == model[21] && !f, "R11 out-of-range inject ignored", {q, 15'(0), f}, {model[21], 16'h0000});
        end

        // R11: injection suppresses a simultaneous write
        addr = AW'(22); din = 16'h7777; wr_n = 0; hi_n = 0; lo_n = 0; inj_en = 1; inj_bit = 5'd5;
        step();
        idle();
        rd(AW'(22), 0, 0);
        chk(q == model[22] && f, "R11 write blocked, bit flipped", {q, 15'(0), f}, {model[22], 16'h0001});

        // R2 with R8: partial write over a faulty word keeps the other lane correct
        inject(AW'(23), 5'd14);
        wr(AW'(23), 16'h9900, 0, 1);
        model[23][15:8] = 8'h99;
        rd(AW'(23), 0, 0);
        chk(q == model[23] && !f, "R2 merge over corrected word", {q, 15'(0), f}, {model[23], 16'h0000});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule